// File: doc/BRIEF.md
# GPIO Port with Pin Interrupt Controller

A 32-pin general-purpose I/O port controlled through a small memory-mapped register window. Software selects a direction for each pin. Output pins drive the value held in a data register. The pad levels of all pins are synchronized and can be read back at any time, including pins that are driving.

Every pin also feeds an interrupt detector. A pin can trigger on a low level, a high level, a rising edge or a falling edge. A separate per-pin override makes the pin trigger on both edges. Detected events latch into a pending register that software clears by writing ones. An enable mask combines with the pending bits to drive one interrupt request line.

The register port is a plain single-cycle interface. A write takes effect at the next clock edge. Read data is combinational from the address, and a read has no side effects. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure. Pad multiplexing, pad electrical control and the bridge to a system bus are left to the surrounding logic.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads zero and `pad_oe`, `pad_out` and `irq` are zero.
- R2: `pad_oe` equals the direction register (byte offset 0x04; a 1 makes the pin an output), and `pad_out` equals the data register (0x00). Both registers read back the last value written.
- R3: Offset 0x08 returns the pad level of every pin after a two-flop synchronizer, whatever the pin's direction. A pad change at the inputs is visible there after two clock edges, and writes to 0x08 are ignored.
- R4: Each pin has a 2-bit trigger code: 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. Pin n < 16 uses bits [2n+1:2n] of the word at 0x0C. Pin n >= 16 uses bits [2(n-16)+1:2(n-16)] of the word at 0x10.
- R5: An edge is found by comparing the synchronized level with its value one cycle earlier. A pad transition sets the pending bit three clock edges after the pad changes, and it sets that bit only once.
- R6: When bit n of the both-edges register (0x1C) is 1, pin n triggers on every transition and its 2-bit code has no effect.
- R7: The pending register (0x18) is write-one-to-clear. Writing 1 to bit n clears that bit, and writing 0 leaves it unchanged.
- R8: A level condition sets its pending bit again on every cycle while the condition holds.
- R9: If a detected event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: `irq` is 1 exactly when some bit is 1 in both the pending register and the enable mask (0x14). The mask resets to zero.
- R11: Reads at unmapped offsets (0x20 and above, or any offset that is not a multiple of 4) return zero, and writes there change nothing.
- R12: A write to the pending register never sets a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken at the clock edge |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Output data driven toward the pads |
| pad_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Interrupt request (pending AND mask) |

## Verification
The bench builds the block with its default NPINS of 32. With that value the second trigger-configuration word is fully populated, so the pins that decode their code from the upper word (pin 20 in the directed cases) are reachable. Every status, mask and both-edge bit is present too, so full-word writes and clears exercise the whole vector. A bench-side model of the synchronizer, the detector and the pending register is compared on every cycle. Random register traffic, which also hits unmapped and misaligned offsets, is mixed with random pad toggles.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PAD    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_BOTH   = 8'h1C;

  typedef enum logic [1:0] {
    TRIG_LVL_LO = 2'd0,
    TRIG_LVL_HI = 2'd1,
    TRIG_RISE   = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a history flop for edge detection.
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] cur_lvl,
  output logic [W-1:0] prev_lvl
);
  logic [W-1:0] meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign cur_lvl  = sync_q;
  assign prev_lvl = hist_q;
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
// Per-pin trigger evaluation; the both-edges bit overrides the 2-bit code.
module gpio_trig_detect
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]   cur_lvl,
  input  logic [NPINS-1:0]   prev_lvl,
  input  logic [2*NPINS-1:0] trig_cfg,
  input  logic [NPINS-1:0]   any_edge,
  output logic [NPINS-1:0]   hit
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] code;
    logic       rise, fall, pin_hit;

    assign code = trig_cfg[2*p +: 2];
    assign rise = cur_lvl[p] & ~prev_lvl[p];
    assign fall = ~cur_lvl[p] & prev_lvl[p];

    always_comb begin
      if (any_edge[p]) begin
        pin_hit = rise | fall;
      end else begin
        case (trig_e'(code))
          TRIG_LVL_LO: pin_hit = ~cur_lvl[p];
          TRIG_LVL_HI: pin_hit = cur_lvl[p];
          TRIG_RISE:   pin_hit = rise;
          default:     pin_hit = fall;
        endcase
      end
    end

    assign hit[p] = pin_hit;
  end
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
// Register window: storage, write decode, W1C pending with set priority, read mux.
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [NPINS-1:0]      pad_lvl,
  input  logic [NPINS-1:0]      hit,
  output logic [NPINS-1:0]      data_q,
  output logic [NPINS-1:0]      dir_q,
  output logic [2*NPINS-1:0]    trig_cfg,
  output logic [NPINS-1:0]      mask_q,
  output logic [NPINS-1:0]      stat_q,
  output logic [NPINS-1:0]      both_q
);
  // Pins 0..15 live in the low word; the rest in the high word (NPINS 17..32).
  localparam int HI_BITS = 2*NPINS - REG_W;

  logic [REG_W-1:0]   cfg_lo_q;
  logic [HI_BITS-1:0] cfg_hi_q;
  logic [NPINS-1:0]   clr_vec;

  assign clr_vec = (reg_wr && reg_addr == OFS_STAT) ? reg_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      mask_q   <= '0;
      both_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_DATA:   data_q   <= reg_wdata[NPINS-1:0];
        OFS_DIR:    dir_q    <= reg_wdata[NPINS-1:0];
        OFS_CFG_LO: cfg_lo_q <= reg_wdata;
        OFS_CFG_HI: cfg_hi_q <= reg_wdata[HI_BITS-1:0];
        OFS_MASK:   mask_q   <= reg_wdata[NPINS-1:0];
        OFS_BOTH:   both_q   <= reg_wdata[NPINS-1:0];
        default: ;
      endcase
    end
  end

  // Detected events take priority over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_vec) | hit;
  end

  assign trig_cfg = {cfg_hi_q, cfg_lo_q};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_DATA:   reg_rdata[NPINS-1:0]   = data_q;
      OFS_DIR:    reg_rdata[NPINS-1:0]   = dir_q;
      OFS_PAD:    reg_rdata[NPINS-1:0]   = pad_lvl;
      OFS_CFG_LO: reg_rdata              = cfg_lo_q;
      OFS_CFG_HI: reg_rdata[HI_BITS-1:0] = cfg_hi_q;
      OFS_MASK:   reg_rdata[NPINS-1:0]   = mask_q;
      OFS_STAT:   reg_rdata[NPINS-1:0]   = stat_q;
      OFS_BOTH:   reg_rdata[NPINS-1:0]   = both_q;
      default:    reg_rdata              = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  logic [NPINS-1:0]   cur_lvl, prev_lvl, hit;
  logic [NPINS-1:0]   data_q, dir_q, mask_q, stat_q, both_q;
  logic [2*NPINS-1:0] trig_cfg;

  gpio_sync #(.W(NPINS)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .cur_lvl  (cur_lvl),
    .prev_lvl (prev_lvl)
  );

  gpio_trig_detect #(.NPINS(NPINS)) detect_i (
    .cur_lvl  (cur_lvl),
    .prev_lvl (prev_lvl),
    .trig_cfg (trig_cfg),
    .any_edge (both_q),
    .hit      (hit)
  );

  gpio_regfile #(.NPINS(NPINS)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_lvl   (cur_lvl),
    .hit       (hit),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .trig_cfg  (trig_cfg),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .both_q    (both_q)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [7:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  hit,
  input logic [NPINS-1:0]  stat_q,
  input logic [NPINS-1:0]  mask_q,
  input logic              irq
);
  // R9 / R8: every detected event is pending on the following cycle.
  p_hit_latched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~stat_q) == '0));

  // R7: a written one clears its bit unless an event hit it.
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STAT) |=>
      ((stat_q & $past(reg_wdata[NPINS-1:0]) & ~$past(hit)) == '0));

  // R12: a pending bit only rises because of a detected event.
  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

  // R2: direction write reaches the output enables.
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DIR) |=> (pad_oe == $past(reg_wdata[NPINS-1:0])));

  // R10: request silent with mask clear, raised when a pending bit is enabled.
  p_mask_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  p_irq_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & mask_q) != '0) |-> irq);

  // R11: unmapped and misaligned offsets read zero.
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= 8'h20 || reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pad_oe    (pad_oe),
  .hit       (hit),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .irq       (irq)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] pad_q = '0;

  always #4 clk = ~clk;

  gpio_irq_port #(.NPINS(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // Behavioural model built from the requirements.
  logic [31:0] m_data, m_dir, m_cfglo, m_cfghi, m_mask, m_stat, m_both;
  logic [31:0] m_s1, m_s2, m_prev;

  function automatic logic [31:0] f_hit(logic [31:0] cur, logic [31:0] prv,
                                        logic [31:0] lo, logic [31:0] hi,
                                        logic [31:0] both);
    logic [31:0] h;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c;
      c = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      if (both[i])       h[i] = cur[i] ^ prv[i];
      else if (c == 2'd0) h[i] = ~cur[i];
      else if (c == 2'd1) h[i] = cur[i];
      else if (c == 2'd2) h[i] = cur[i] & ~prv[i];
      else               h[i] = ~cur[i] & prv[i];
    end
    return h;
  endfunction

  function automatic logic [31:0] f_read(logic [7:0] a);
    case (a)
      8'h00: return m_data;
      8'h04: return m_dir;
      8'h08: return m_s2;
      8'h0C: return m_cfglo;
      8'h10: return m_cfghi;
      8'h14: return m_mask;
      8'h18: return m_stat;
      8'h1C: return m_both;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string f_tag(logic [7:0] a);
    case (a)
      8'h00, 8'h04: return "R2 data/dir readback";
      8'h08:        return "R3 pad level";
      8'h0C, 8'h10: return "R4 trigger words";
      8'h14:        return "R10 mask";
      8'h18:        return "R7 pending";
      8'h1C:        return "R6 both-edge";
      default:      return "R11 unmapped";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= '0; m_dir <= '0; m_cfglo <= '0; m_cfghi <= '0;
      m_mask <= '0; m_stat <= '0; m_both <= '0;
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
    end else begin
      m_s1 <= pad_in;
      m_s2 <= m_s1;
      m_prev <= m_s2;
      m_stat <= (m_stat & ~((reg_wr && reg_addr == 8'h18) ? reg_wdata : 32'h0))
                | f_hit(m_s2, m_prev, m_cfglo, m_cfghi, m_both);
      if (reg_wr) begin
        case (reg_addr)
          8'h00: m_data  <= reg_wdata;
          8'h04: m_dir   <= reg_wdata;
          8'h0C: m_cfglo <= reg_wdata;
          8'h10: m_cfghi <= reg_wdata;
          8'h14: m_mask  <= reg_wdata;
          8'h1C: m_both  <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One cycle: compare outputs against the model, then drive new inputs.
  task automatic step(logic wr, logic [7:0] a, logic [31:0] d, logic [31:0] p);
    @(negedge clk);
    check(f_tag(reg_addr), reg_rdata, f_read(reg_addr));
    check("R10 irq", {31'h0, irq}, {31'h0, |(m_stat & m_mask)});
    check("R2 pad_out", pad_out, m_data);
    check("R2 pad_oe", pad_oe, m_dir);
    reg_wr = wr; reg_addr = a; reg_wdata = d; pad_in = p;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    step(1'b1, a, d, pad_q);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h18, 32'h0, pad_q);
  endtask

  task automatic peek(logic [7:0] a, logic [31:0] exp, string tag);
    step(1'b0, a, 32'h0, pad_q);
    #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic set_pad(logic [31:0] p);
    pad_q = p;
    step(1'b0, 8'h18, 32'h0, pad_q);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      reg_addr = 8'(i * 4);
      #1;
      check("R1 reset read", reg_rdata, 32'h0);
      check("R1 reset pad_oe", pad_oe, 32'h0);
      check("R1 reset pad_out", pad_out, 32'h0);
      check("R1 reset irq", {31'h0, irq}, 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R8 / R9: level-low default with pads low keeps re-setting.
    peek(8'h18, 32'hFFFF_FFFF, "R8 level-low pending");
    wr_reg(8'h18, 32'hFFFF_FFFF);
    peek(8'h18, 32'hFFFF_FFFF, "R9 set wins over clear");
    peek(8'h18, 32'hFFFF_FFFF, "R8 level still holds");

    // R4: all level-high, pin 20 rising via second word bits [9:8].
    wr_reg(8'h0C, 32'h5555_5555);
    wr_reg(8'h10, 32'h5555_5655);
    wr_reg(8'h18, 32'hFFFF_FFFF);
    peek(8'h18, 32'h0, "R7 clear all");
    wr_reg(8'h18, 32'hFFFF_FFFF);
    peek(8'h18, 32'h0, "R12 write never sets");
    set_pad(32'h0010_0000);
    idle(3);
    peek(8'h18, 32'h0010_0000, "R4 pin 20 rising via second word");
    wr_reg(8'h18, 32'h0);
    peek(8'h18, 32'h0010_0000, "R7 write zero no effect");
    wr_reg(8'h18, 32'h0010_0000);
    peek(8'h18, 32'h0, "R7 write one clears");
    idle(3);
    peek(8'h18, 32'h0, "R5 edge sets once");

    // R10: mask gating
    wr_reg(8'h14, 32'h0010_0000);
    #1 check("R10 no pending no irq", {31'h0, irq}, 32'h0);
    set_pad(32'h0);
    idle(4);
    peek(8'h18, 32'h0, "R4 falling ignored by rising code");
    set_pad(32'h0010_0000);
    idle(3);
    peek(8'h18, 32'h0010_0000, "R5 second rise");
    check("R10 enabled pending raises irq", {31'h0, irq}, 32'h1);
    wr_reg(8'h14, 32'h0);
    peek(8'h18, 32'h0010_0000, "R10 pending kept");
    check("R10 masked irq low", {31'h0, irq}, 32'h0);

    // R6: both-edge override on pin 3 (its code says level high)
    wr_reg(8'h1C, 32'h0000_0008);
    wr_reg(8'h18, 32'hFFFF_FFFF);
    peek(8'h18, 32'h0, "R6 precondition");
    set_pad(32'h0010_0008);
    idle(3);
    peek(8'h18, 32'h0000_0008, "R6 rising transition");
    wr_reg(8'h18, 32'h0000_0008);
    idle(2);
    peek(8'h18, 32'h0, "R6 level code ignored");
    set_pad(32'h0010_0000);
    idle(3);
    peek(8'h18, 32'h0000_0008, "R6 falling transition");

    // R2 / R3
    wr_reg(8'h04, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'hDEAD_BEEF);
    set_pad(32'h1234_5678);
    idle(2);
    peek(8'h08, 32'h1234_5678, "R3 pad level with outputs enabled");
    check("R2 pad_oe", pad_oe, 32'hFFFF_FFFF);
    check("R2 pad_out", pad_out, 32'hDEAD_BEEF);
    wr_reg(8'h08, 32'h0);
    peek(8'h08, 32'h1234_5678, "R3 pad write ignored");

    // R11
    peek(8'h20, 32'h0, "R11 read 0x20");
    peek(8'h05, 32'h0, "R11 read misaligned");
    peek(8'hFC, 32'h0, "R11 read 0xFC");
    wr_reg(8'h24, 32'h0);
    wr_reg(8'h01, 32'h0);
    peek(8'h00, 32'hDEAD_BEEF, "R11 writes ignored");

    // Random phase, model-checked every cycle.
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [7:0] a;
      sel = $urandom_range(0, 9);
      if (sel < 8)       a = 8'(sel * 4);
      else if (sel == 8) a = 8'h20 | 8'($urandom_range(0, 223));
      else               a = 8'($urandom_range(0, 7) * 4 + 1);
      pad_q = pad_q ^ ($urandom & $urandom & $urandom);
      step(($urandom_range(0, 3) == 0), a, $urandom, pad_q);
    end
    idle(2);
    finish_run();
  end
endmodule